// File: doc/BRIEF.md
# Configuration Space Access Bridge

The bridge turns a configuration request of 1, 2 or 4 bytes into aligned 32-bit accesses on one of two register windows. Each request names a bus, a device/function number, a byte offset, a size and write data. Bus 0 selects the local root-port register window. Bus 1 selects the downstream configuration window, and only while the link is up. Reads return the addressed bytes right-justified. Writes read the containing word first and then write it back with only the addressed byte lanes replaced.

Requests arrive on a valid/ready channel and only one is in flight at a time. `req_ready` is high only while the bridge is idle. A requester that sees `req_ready` low keeps `req_valid` and every request field steady until a cycle in which both are high; that cycle is the acceptance. The result comes back as a one-cycle `rsp_done` pulse carrying data and a status. Each window is a plain memory port: an enable, a write enable, a word address and write data. Read data appears on the cycle after an enabled read.

For a bus-1 target the bridge learns the link state on its own. It first reads the local-window word at byte offset 0x80 and tests bit 29.

Top module: `cfg_access_bridge`

## Requirements
- R1: `req_ready` is high exactly when the bridge is idle; after an acceptance it stays low until the response pulse has been given, so at most one request is outstanding.
- R2: Every accepted request produces exactly one `rsp_done` pulse of one cycle, with status 2'b00 = success, 2'b01 = target not found, 2'b10 = illegal size/offset.
- R3: A request whose bus is neither 0 nor 1, or whose device/function is not 0, completes with status 2'b01 and data 32'hFFFFFFFF, and touches neither window.
- R4: For a bus-1 request the bridge first reads the local word at byte offset 0x80. If its bit 29 is 0, the request completes with status 2'b01 and data all ones, and the downstream window is not accessed.
- R5: A request whose size is not 1, 2 or 4, or whose two low offset bits plus size exceed 4, completes with status 2'b10 and data all ones, and touches no window. The target check of R3 takes priority over this check.
- R6: Bus-0 accesses use the local window and bus-1 accesses use the downstream window, at word address = offset with its two low bits dropped.
- R7: A successful read returns the `size` bytes starting at byte lane offset[1:0] in bits [8*size-1:0], with the upper bits zero.
- R8: A successful write reads the word, then writes it back to the same address with lanes offset[1:0] .. offset[1:0]+size-1 taken from the low bytes of the write data and all other lanes unchanged. The response data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle, request accepted when valid is also high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | BUS_W | Target bus number |
| req_devfn | input | DEVFN_W | Target device/function number |
| req_offset | input | OFS_W | Byte offset in configuration space |
| req_size | input | SIZE_W | Access size in bytes |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 32 | Read data or all ones on rejection, valid with rsp_done |
| rsp_status | output | 2 | Completion status, valid with rsp_done |
| loc_en | output | 1 | Local window access enable |
| loc_we | output | 1 | Local window write enable |
| loc_addr | output | OFS_W-2 | Local window word address |
| loc_wdata | output | 32 | Local window write data |
| loc_rdata | input | 32 | Local window read data, one cycle after enable |
| dn_en | output | 1 | Downstream window access enable |
| dn_we | output | 1 | Downstream window write enable |
| dn_addr | output | OFS_W-2 | Downstream window word address |
| dn_wdata | output | 32 | Downstream window write data |
| dn_rdata | input | 32 | Downstream window read data, one cycle after enable |

## Verification
The assertions check on every cycle the rules that hold for any request:
- the single outstanding request and the one-cycle response pulse;
- all-ones data on every rejection;
- the two windows never enabled together;
- each window write being preceded two cycles earlier by a read of the same word;
- each downstream read being preceded by a link-word read that showed the link bit set.

Only the bench scenarios can show the values themselves. These are the right-justified read bytes, the lane merge of sub-word writes as seen on read-back, the order in which target and size checks take priority, and the absence of window traffic for rejected requests.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam int CFG_DW     = 32;
  localparam int CFG_LANES  = CFG_DW / 8;
  localparam int CFG_LANE_W = $clog2(CFG_LANES);

  typedef enum logic [1:0] {
    CST_OK       = 2'b00,
    CST_NOTFOUND = 2'b01,
    CST_BADSIZE  = 2'b10
  } cfg_status_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_LINK_REQ,
    ST_LINK_WAIT,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR,
    ST_RESP
  } cfg_state_e;
endpackage

// File: rtl/cfgb_decode.sv
module cfgb_decode import cfgb_pkg::*; #(
  parameter int BUS_W    = 8,
  parameter int DEVFN_W  = 8,
  parameter int OFS_W    = 12,
  parameter int SIZE_W   = 3,
  parameter int DOWN_BUS = 1
) (
  input  logic [BUS_W-1:0]            bus,
  input  logic [DEVFN_W-1:0]          devfn,
  input  logic [OFS_W-1:0]            offset,
  input  logic [SIZE_W-1:0]           size,
  output logic                        tgt_ok,
  output logic                        down_sel,
  output logic                        size_ok,
  output logic [CFG_LANE_W-1:0]       lane,
  output logic [OFS_W-CFG_LANE_W-1:0] word_addr,
  output logic [CFG_DW-1:0]           mask
);
  logic is_root;
  logic pow2;
  int   lo;
  int   hi;

  assign lane      = offset[CFG_LANE_W-1:0];
  assign word_addr = offset[OFS_W-1:CFG_LANE_W];
  assign is_root   = (bus == '0);
  assign down_sel  = (bus == BUS_W'(DOWN_BUS));
  assign tgt_ok    = (is_root || down_sel) && (devfn == '0);
  assign pow2      = (size != '0) && ((size & (size - SIZE_W'(1))) == '0);

  always_comb begin
    lo      = int'(lane);
    hi      = lo + int'(size);
    size_ok = pow2 && (int'(size) <= CFG_LANES) && (hi <= CFG_LANES);
    for (int b = 0; b < CFG_LANES; b++) begin
      mask[b*8 +: 8] = ((b >= lo) && (b < hi)) ? 8'hFF : 8'h00;
    end
  end
endmodule

// File: rtl/cfgb_lane_merge.sv
module cfgb_lane_merge import cfgb_pkg::*; (
  input  logic [CFG_DW-1:0]     word,
  input  logic [CFG_DW-1:0]     wdata,
  input  logic [CFG_LANE_W-1:0] lane,
  input  logic [CFG_DW-1:0]     mask,
  output logic [CFG_DW-1:0]     rd_just,
  output logic [CFG_DW-1:0]     wr_merged
);
  localparam int SH_W = CFG_LANE_W + 3;

  logic [SH_W-1:0]   shamt;
  logic [CFG_DW-1:0] wsh;

  assign shamt   = {lane, 3'b000};
  assign rd_just = (word & mask) >> shamt;
  assign wsh     = wdata << shamt;

  for (genvar g = 0; g < CFG_LANES; g++) begin : g_lane
    assign wr_merged[g*8 +: 8] = mask[g*8] ? wsh[g*8 +: 8] : word[g*8 +: 8];
  end
endmodule

// File: rtl/cfgb_ctrl.sv
module cfgb_ctrl import cfgb_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_fire,
  input  logic        tgt_ok,
  input  logic        size_ok,
  input  logic        down_sel,
  input  logic        is_write,
  input  logic        link_bit,
  output cfg_state_e  state_q,
  output cfg_status_e status_q
);
  cfg_state_e  state_d;
  cfg_status_e status_d;

  always_comb begin
    state_d  = state_q;
    status_d = status_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_fire) begin
          state_d  = ST_DECIDE;
          status_d = CST_OK;
        end
      end
      ST_DECIDE: begin
        if (!tgt_ok) begin
          status_d = CST_NOTFOUND;
          state_d  = ST_RESP;
        end else if (!size_ok) begin
          status_d = CST_BADSIZE;
          state_d  = ST_RESP;
        end else if (down_sel) begin
          state_d  = ST_LINK_REQ;
        end else begin
          state_d  = ST_RD_REQ;
        end
      end
      ST_LINK_REQ:  state_d = ST_LINK_WAIT;
      ST_LINK_WAIT: begin
        if (link_bit) begin
          state_d = ST_RD_REQ;
        end else begin
          status_d = CST_NOTFOUND;
          state_d  = ST_RESP;
        end
      end
      ST_RD_REQ:  state_d = ST_RD_WAIT;
      ST_RD_WAIT: state_d = is_write ? ST_WR : ST_RESP;
      ST_WR:      state_d = ST_RESP;
      ST_RESP:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      status_q <= CST_OK;
    end else begin
      state_q  <= state_d;
      status_q <= status_d;
    end
  end
endmodule

// File: rtl/cfg_access_bridge.sv
module cfg_access_bridge import cfgb_pkg::*; #(
  parameter int BUS_W    = 8,
  parameter int DEVFN_W  = 8,
  parameter int OFS_W    = 12,
  parameter int SIZE_W   = 3,
  parameter int DOWN_BUS = 1,
  parameter int LINK_OFS = 'h80,
  parameter int LINK_BIT = 29
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic [BUS_W-1:0]            req_bus,
  input  logic [DEVFN_W-1:0]          req_devfn,
  input  logic [OFS_W-1:0]            req_offset,
  input  logic [SIZE_W-1:0]           req_size,
  input  logic [CFG_DW-1:0]           req_wdata,
  output logic                        rsp_done,
  output logic [CFG_DW-1:0]           rsp_data,
  output logic [1:0]                  rsp_status,
  output logic                        loc_en,
  output logic                        loc_we,
  output logic [OFS_W-CFG_LANE_W-1:0] loc_addr,
  output logic [CFG_DW-1:0]           loc_wdata,
  input  logic [CFG_DW-1:0]           loc_rdata,
  output logic                        dn_en,
  output logic                        dn_we,
  output logic [OFS_W-CFG_LANE_W-1:0] dn_addr,
  output logic [CFG_DW-1:0]           dn_wdata,
  input  logic [CFG_DW-1:0]           dn_rdata
);
  localparam int WIN_AW = OFS_W - CFG_LANE_W;
  localparam logic [OFS_W-1:0]  LINK_BYTE = OFS_W'(LINK_OFS);
  localparam logic [WIN_AW-1:0] LINK_WORD = LINK_BYTE[OFS_W-1:CFG_LANE_W];

  // latched request
  logic               rq_write;
  logic [BUS_W-1:0]   rq_bus;
  logic [DEVFN_W-1:0] rq_devfn;
  logic [OFS_W-1:0]   rq_offset;
  logic [SIZE_W-1:0]  rq_size;
  logic [CFG_DW-1:0]  rq_wdata;
  logic [CFG_DW-1:0]  word_q;

  logic                  req_fire;
  logic                  tgt_ok;
  logic                  down_sel;
  logic                  size_ok;
  logic [CFG_LANE_W-1:0] lane;
  logic [WIN_AW-1:0]     word_addr;
  logic [CFG_DW-1:0]     mask;
  logic [CFG_DW-1:0]     rd_just;
  logic [CFG_DW-1:0]     wr_merged;
  logic                  win_access;
  cfg_state_e            state_q;
  cfg_status_e           status_q;

  assign req_ready = (state_q == ST_IDLE);
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rq_write  <= 1'b0;
      rq_bus    <= '0;
      rq_devfn  <= '0;
      rq_offset <= '0;
      rq_size   <= '0;
      rq_wdata  <= '0;
    end else if (req_fire) begin
      rq_write  <= req_write;
      rq_bus    <= req_bus;
      rq_devfn  <= req_devfn;
      rq_offset <= req_offset;
      rq_size   <= req_size;
      rq_wdata  <= req_wdata;
    end
  end

  cfgb_decode #(
    .BUS_W    (BUS_W),
    .DEVFN_W  (DEVFN_W),
    .OFS_W    (OFS_W),
    .SIZE_W   (SIZE_W),
    .DOWN_BUS (DOWN_BUS)
  ) u_decode (
    .bus       (rq_bus),
    .devfn     (rq_devfn),
    .offset    (rq_offset),
    .size      (rq_size),
    .tgt_ok    (tgt_ok),
    .down_sel  (down_sel),
    .size_ok   (size_ok),
    .lane      (lane),
    .word_addr (word_addr),
    .mask      (mask)
  );

  cfgb_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_fire (req_fire),
    .tgt_ok   (tgt_ok),
    .size_ok  (size_ok),
    .down_sel (down_sel),
    .is_write (rq_write),
    .link_bit (loc_rdata[LINK_BIT]),
    .state_q  (state_q),
    .status_q (status_q)
  );

  // word captured from the selected window one cycle after the read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (state_q == ST_RD_WAIT) begin
      word_q <= down_sel ? dn_rdata : loc_rdata;
    end
  end

  cfgb_lane_merge u_merge (
    .word      (word_q),
    .wdata     (rq_wdata),
    .lane      (lane),
    .mask      (mask),
    .rd_just   (rd_just),
    .wr_merged (wr_merged)
  );

  assign win_access = (state_q == ST_RD_REQ) || (state_q == ST_WR);

  assign loc_en    = (state_q == ST_LINK_REQ) || (win_access && !down_sel);
  assign loc_we    = (state_q == ST_WR) && !down_sel;
  assign loc_addr  = (state_q == ST_LINK_REQ) ? LINK_WORD : word_addr;
  assign loc_wdata = wr_merged;

  assign dn_en    = win_access && down_sel;
  assign dn_we    = (state_q == ST_WR) && down_sel;
  assign dn_addr  = word_addr;
  assign dn_wdata = wr_merged;

  assign rsp_done   = (state_q == ST_RESP);
  assign rsp_status = status_q;
  always_comb begin
    if (status_q != CST_OK) rsp_data = '1;
    else if (rq_write)      rsp_data = '0;
    else                    rsp_data = rd_just;
  end
endmodule

// File: rtl/cfgb_bridge_chk.sv
module cfgb_bridge_chk #(
  parameter int OFS_W    = 12,
  parameter int LINK_OFS = 'h80,
  parameter int LINK_BIT = 29
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_done,
  input logic [31:0]      rsp_data,
  input logic [1:0]       rsp_status,
  input logic             loc_en,
  input logic             loc_we,
  input logic [OFS_W-3:0] loc_addr,
  input logic [31:0]      loc_rdata,
  input logic             dn_en,
  input logic             dn_we,
  input logic [OFS_W-3:0] dn_addr
);
  localparam logic [OFS_W-1:0] LINK_BYTE = OFS_W'(LINK_OFS);
  localparam logic [OFS_W-3:0] LINK_WORD = LINK_BYTE[OFS_W-1:2];

  // R1: one request outstanding
  p_one_outstanding_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R2: response is a single-cycle pulse with a defined status
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  p_status_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (rsp_status != 2'b11));

  // R3: rejections carry all ones
  p_reject_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && (rsp_status != 2'b00)) |-> (rsp_data == 32'hFFFF_FFFF));

  // R6: only one window is driven at a time
  p_window_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(loc_en && dn_en));

  // R8: every write is preceded by a read of the same word
  p_rmw_loc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_en && loc_we) |->
      ($past(loc_en, 2) && !$past(loc_we, 2) && ($past(loc_addr, 2) == loc_addr)));
  p_rmw_dn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_en && dn_we) |->
      ($past(dn_en, 2) && !$past(dn_we, 2) && ($past(dn_addr, 2) == dn_addr)));

  // R4: downstream read only after a link word with the link bit set
  p_link_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_en && !dn_we) |->
      ($past(loc_rdata[LINK_BIT]) && $past(loc_en, 2) && ($past(loc_addr, 2) == LINK_WORD)));
endmodule

bind cfg_access_bridge cfgb_bridge_chk #(
  .OFS_W    (OFS_W),
  .LINK_OFS (LINK_OFS),
  .LINK_BIT (LINK_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_done   (rsp_done),
  .rsp_data   (rsp_data),
  .rsp_status (rsp_status),
  .loc_en     (loc_en),
  .loc_we     (loc_we),
  .loc_addr   (loc_addr),
  .loc_rdata  (loc_rdata),
  .dn_en      (dn_en),
  .dn_we      (dn_we),
  .dn_addr    (dn_addr)
);

// File: tb/cfg_access_bridge_test.sv
module cfg_access_bridge_test;
  localparam int WORDS = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [7:0]  req_devfn = '0;
  logic [11:0] req_offset = '0;
  logic [2:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_done;
  logic [31:0] rsp_data;
  logic [1:0]  rsp_status;
  logic        loc_en, loc_we, dn_en, dn_we;
  logic [9:0]  loc_addr, dn_addr;
  logic [31:0] loc_wdata, dn_wdata;
  logic [31:0] loc_rdata = '0;
  logic [31:0] dn_rdata = '0;

  always #4 clk = ~clk;  // 125 MHz

  cfg_access_bridge uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bus(req_bus), .req_devfn(req_devfn), .req_offset(req_offset),
    .req_size(req_size), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_data(rsp_data), .rsp_status(rsp_status),
    .loc_en(loc_en), .loc_we(loc_we), .loc_addr(loc_addr),
    .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
    .dn_en(dn_en), .dn_we(dn_we), .dn_addr(dn_addr),
    .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
  );

  // window memories seen by the bridge
  logic [31:0] loc_mem [WORDS];
  logic [31:0] dn_mem  [WORDS];
  // bench-side expectation of the memory contents
  logic [31:0] sh_loc [WORDS];
  logic [31:0] sh_dn  [WORDS];

  int loc_cnt = 0;
  int dn_cnt  = 0;

  always @(posedge clk) begin
    if (loc_en) begin
      if (loc_we) loc_mem[loc_addr] <= loc_wdata;
      loc_rdata <= loc_mem[loc_addr];
      loc_cnt <= loc_cnt + 1;
    end
    if (dn_en) begin
      if (dn_we) dn_mem[dn_addr] <= dn_wdata;
      dn_rdata <= dn_mem[dn_addr];
      dn_cnt <= dn_cnt + 1;
    end
  end

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard
  logic [31:0] exp_data_q[$];
  logic [1:0]  exp_stat_q[$];
  string       tag_q[$];
  bit          pulse_seen = 1'b0;

  always @(negedge clk) begin
    if (pulse_seen) begin
      check("R2 done pulse width", {31'd0, rsp_done}, 32'd0);
      pulse_seen = 1'b0;
    end
    if (rst_n && rsp_done) begin
      if (exp_data_q.size() == 0) begin
        check("R2 unexpected done", 32'd1, 32'd0);
      end else begin
        string t;
        logic [31:0] ed;
        logic [1:0]  es;
        t  = tag_q.pop_front();
        ed = exp_data_q.pop_front();
        es = exp_stat_q.pop_front();
        check({t, " status"}, {30'd0, rsp_status}, {30'd0, es});
        check({t, " data"}, rsp_data, ed);
      end
      pulse_seen = 1'b1;
    end
  end

  // expected result from the requirements; updates the shadow on writes
  task automatic predict(input bit w, input logic [7:0] bus, input logic [7:0] devfn,
                         input logic [11:0] ofs, input logic [2:0] sz,
                         input logic [31:0] wd, output logic [31:0] ed,
                         output logic [1:0] es);
    int lane;
    logic [31:0] word;
    lane = int'(ofs[1:0]);
    ed = 32'hFFFF_FFFF;
    if (bus > 8'd1 || devfn != 8'd0) begin
      es = 2'b01;
    end else if (!(sz == 3'd1 || sz == 3'd2 || sz == 3'd4) || (lane + int'(sz) > 4)) begin
      es = 2'b10;
    end else if (bus == 8'd1 && !sh_loc[32][29]) begin
      es = 2'b01;
    end else begin
      es = 2'b00;
      word = (bus == 8'd0) ? sh_loc[ofs[11:2]] : sh_dn[ofs[11:2]];
      if (w) begin
        for (int i = 0; i < int'(sz); i++) word[(lane+i)*8 +: 8] = wd[i*8 +: 8];
        if (bus == 8'd0) sh_loc[ofs[11:2]] = word;
        else             sh_dn[ofs[11:2]]  = word;
        ed = 32'd0;
      end else begin
        ed = 32'd0;
        for (int i = 0; i < int'(sz); i++) ed[i*8 +: 8] = word[(lane+i)*8 +: 8];
      end
    end
  endtask

  // driver: pushes the expectation, drives the request, waits for its result
  task automatic issue(input string tag, input bit w, input logic [7:0] bus,
                       input logic [7:0] devfn, input logic [11:0] ofs,
                       input logic [2:0] sz, input logic [31:0] wd);
    logic [31:0] ed;
    logic [1:0]  es;
    predict(w, bus, devfn, ofs, sz, wd, ed, es);
    exp_data_q.push_back(ed);
    exp_stat_q.push_back(es);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_bus = bus; req_devfn = devfn;
    req_offset = ofs; req_size = sz; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_wdata = 32'hDEAD_BEEF;
    while (exp_data_q.size() != 0) @(negedge clk);
  endtask

  int l0, d0;

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      loc_mem[i] = 32'h5A00_0000 ^ (i * 32'h0001_0203);
      dn_mem[i]  = 32'hC300_0000 ^ (i * 32'h0003_0507);
    end
    loc_mem[32] = 32'h0000_1234;  // link bit 29 clear
    for (int i = 0; i < WORDS; i++) begin
      sh_loc[i] = loc_mem[i];
      sh_dn[i]  = dn_mem[i];
    end
    repeat (3) @(negedge clk);
    // R1/R2 reset state
    check("R1 ready during reset", {31'd0, req_ready}, 32'd1);
    check("R2 done during reset", {31'd0, rsp_done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", {31'd0, req_ready}, 32'd1);

    // R6/R7 reads on bus 0
    issue("R7 rd bus0 word", 1'b0, 8'd0, 8'd0, 12'h010, 3'd4, 32'd0);
    issue("R7 rd bus0 byte1", 1'b0, 8'd0, 8'd0, 12'h011, 3'd1, 32'd0);
    issue("R7 rd bus0 byte3", 1'b0, 8'd0, 8'd0, 12'h013, 3'd1, 32'd0);
    issue("R7 rd bus0 half2", 1'b0, 8'd0, 8'd0, 12'h012, 3'd2, 32'd0);

    // R1 ready low while busy
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_bus = 8'd0; req_devfn = 8'd0;
    req_offset = 12'h014; req_size = 3'd4;
    begin
      logic [31:0] ed; logic [1:0] es;
      predict(1'b0, 8'd0, 8'd0, 12'h014, 3'd4, 32'd0, ed, es);
      exp_data_q.push_back(ed); exp_stat_q.push_back(es); tag_q.push_back("R1 held rd");
    end
    @(negedge clk);
    check("R1 ready low after accept", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    check("R1 ready low while busy", {31'd0, req_ready}, 32'd0);
    req_valid = 1'b0;
    while (exp_data_q.size() != 0) @(negedge clk);

    // R8 sub-word writes with read-back
    issue("R8 wr byte1", 1'b1, 8'd0, 8'd0, 12'h021, 3'd1, 32'hFFFF_FFAB);
    issue("R8 rb byte1", 1'b0, 8'd0, 8'd0, 12'h020, 3'd4, 32'd0);
    issue("R8 wr half2", 1'b1, 8'd0, 8'd0, 12'h022, 3'd2, 32'h1111_BEEF);
    issue("R8 rb half2", 1'b0, 8'd0, 8'd0, 12'h020, 3'd4, 32'd0);
    issue("R8 wr word", 1'b1, 8'd0, 8'd0, 12'h030, 3'd4, 32'h1234_5678);
    issue("R8 rb word", 1'b0, 8'd0, 8'd0, 12'h030, 3'd4, 32'd0);

    // R3 invalid targets: no window traffic
    l0 = loc_cnt; d0 = dn_cnt;
    issue("R3 bus2 rd", 1'b0, 8'd2, 8'd0, 12'h010, 3'd4, 32'd0);
    issue("R3 devfn1 wr", 1'b1, 8'd0, 8'd1, 12'h030, 3'd4, 32'hAAAA_AAAA);
    issue("R3 bus255 bad size", 1'b0, 8'd255, 8'd0, 12'h041, 3'd4, 32'd0);
    check("R3 no local access", loc_cnt, l0);
    check("R3 no downstream access", dn_cnt, d0);
    issue("R3 rb unchanged", 1'b0, 8'd0, 8'd0, 12'h030, 3'd4, 32'd0);

    // R5 illegal size/offset
    l0 = loc_cnt; d0 = dn_cnt;
    issue("R5 size3", 1'b0, 8'd0, 8'd0, 12'h040, 3'd3, 32'd0);
    issue("R5 half crosses", 1'b1, 8'd0, 8'd0, 12'h043, 3'd2, 32'h0000_FFFF);
    issue("R5 word misaligned", 1'b0, 8'd0, 8'd0, 12'h041, 3'd4, 32'd0);
    issue("R5 size0", 1'b0, 8'd0, 8'd0, 12'h040, 3'd0, 32'd0);
    check("R5 no local access", loc_cnt, l0);
    check("R5 no downstream access", dn_cnt, d0);

    // R4 link down on bus 1
    l0 = loc_cnt; d0 = dn_cnt;
    issue("R4 bus1 link down", 1'b0, 8'd1, 8'd0, 12'h004, 3'd4, 32'd0);
    check("R4 link word read once", loc_cnt - l0, 32'd1);
    check("R4 no downstream access", dn_cnt, d0);

    // set link bit 29 via byte lane 3 of local offset 0x80
    issue("R8 set link byte", 1'b1, 8'd0, 8'd0, 12'h083, 3'd1, 32'h0000_0020);
    issue("R6 rd bus1 word", 1'b0, 8'd1, 8'd0, 12'h004, 3'd4, 32'd0);
    issue("R7 rd bus1 byte2", 1'b0, 8'd1, 8'd0, 12'h00A, 3'd1, 32'd0);
    issue("R8 wr bus1 half1", 1'b1, 8'd1, 8'd0, 12'h005, 3'd2, 32'h0000_C0DE);
    issue("R8 rb bus1 word", 1'b0, 8'd1, 8'd0, 12'h004, 3'd4, 32'd0);
    issue("R6 local untouched", 1'b0, 8'd0, 8'd0, 12'h004, 3'd4, 32'd0);
    issue("R3 bus1 devfn8", 1'b0, 8'd1, 8'd8, 12'h004, 3'd4, 32'd0);

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule